// File: doc/BRIEF.md
# USB Host Interrupt Status and Enable Register

This block keeps the sticky interrupt status of a USB host controller and turns it into one interrupt line. Two event sources live in a fast core clock domain: change strobes from the root hub and its downstream ports, and bit 15 of the 16-bit frame counter. Each event sets its own status bit, and that bit stays set until software clears it. Software sits on a slower bus clock. It reads the status and enable words through a plain register read port and writes through a valid/ready write port.

A status bit is cleared by writing 1 to its position. The clear is captured on the bus clock and carried into the core domain by a toggle handshake. While a clear is in flight, `wr_ready_o` is low and `clr_busy_o` is high, and every write is held off. Back-pressure rules: a write is taken on a bus rising edge where `wr_valid_i` and `wr_ready_o` are both high. The writer keeps address and data stable until then. `wr_ready_o` does not depend on `wr_valid_i`.

The bus side sees the status through per-bit synchronizers. The interrupt output is formed in the bus domain from those synchronized bits, the per-source enables and a master enable.

Top module: `usbh_int_status`

## Requirements
- R1: After reset, both status words read 0, the enable word reads 0, `irq_o` is 0, `wr_ready_o` is 1 and `clr_busy_o` is 0.
- R2: A one-cycle high on any bit of `rh_evt_i` sets status bit 6 of the word at address 0. Index 0 is the hub itself and indices 1..N_PORTS are the ports.
- R3: A change of `frm_msb_i` in either direction (0 to 1 or 1 to 0) sets status bit 5.
- R4: Status bits are sticky. Once set, they stay set after the event goes away, and the block never clears them by itself.
- R5: A write to address 0 with 1 in bit 6 or bit 5 clears that bit. A 0 in a bit position leaves that bit unchanged.
- R6: No write can set a status bit.
- R7: In the status word, bits 31, 30 (ownership change, never implemented), 29..7 and 4..0 always read 0.
- R8: `irq_o` is 1 exactly when enable bit 31 (master) is 1 and some status bit (6 or 5) is 1 together with the enable bit at the same position of address 1.
- R9: A clear write stalls further writes. `wr_ready_o` falls in the cycle after the write is taken and returns within 6 bus cycles. Once it is back, the cleared bit reads 0. In the half cycle after the write is taken, the bit still reads 1.
- R10: If an event and a clear for the same bit reach the core in the same core cycle, the set wins and the bit stays 1.
- R11: Address 1 holds the enable word: bit 31 master, bit 6 root-hub enable, bit 5 frame enable. It reads back what was written at those bits, and 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| clk_core | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid_i | input | 1 | Write request |
| wr_ready_o | output | 1 | Write accepted when high with valid; low while a clear is in flight |
| wr_addr_i | input | 2 | Write address: 0 status, 1 enable |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data for `rd_addr_i`, combinational |
| rh_evt_i | input | N_PORTS+1 | Root-hub and port change strobes (core domain) |
| frm_msb_i | input | 1 | Bit 15 of the frame number (core domain) |
| irq_o | output | 1 | Interrupt request (bus domain) |
| clr_busy_o | output | 1 | High while a clear request is crossing |

## Verification
An event sets its core register on the next core edge and then passes through two bus-clock synchronizer flops. It is therefore visible at `rd_data_o` and `irq_o` within three bus cycles. The bench waits six bus cycles before comparing against its model. For a clear, the bench samples at the bus falling edge right after acceptance: `wr_ready_o` must be low and the bit still 1. It then counts falling edges until ready returns, with a limit of six, and the bit must read 0 at that point. Inputs change on falling edges of their own clock, so every sample falls midway between rising edges.

// File: rtl/usbh_ints_pkg.sv
package usbh_ints_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 2;
  localparam int BIT_RHSC = 6;
  localparam int BIT_FNOV = 5;
  localparam int BIT_MIE  = 31;
  localparam int N_SRC    = 2;
  localparam int SRC_FN   = 0;
  localparam int SRC_RH   = 1;

  typedef logic [N_SRC-1:0] src_vec_t;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 2'd0,
    A_ENAB = 2'd1
  } reg_addr_e;

  function automatic src_vec_t pick_src(input logic [REG_W-1:0] w);
    src_vec_t r;
    r[SRC_RH] = w[BIT_RHSC];
    r[SRC_FN] = w[BIT_FNOV];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] place_src(input src_vec_t s);
    logic [REG_W-1:0] w;
    w = '0;
    w[BIT_RHSC] = s[SRC_RH];
    w[BIT_FNOV] = s[SRC_FN];
    return w;
  endfunction
endpackage

// File: rtl/usbh_ints_sync.sv
module usbh_ints_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/usbh_ints_clr_xfer.sv
module usbh_ints_clr_xfer #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk_bus,
  input  logic         clk_core,
  input  logic         rst_n,
  input  logic         launch,
  input  logic [W-1:0] mask_in,
  output logic         busy,
  output logic         clr_pulse,
  output logic [W-1:0] clr_mask
);
  logic         req_tgl;
  logic [W-1:0] mask_q;
  logic         req_s;
  logic         req_seen;
  logic         ack_s;

  // bus side: flip the request and hold the mask until acknowledged
  always_ff @(posedge clk_bus or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      mask_q  <= '0;
    end else if (launch) begin
      req_tgl <= ~req_tgl;
      mask_q  <= mask_in;
    end
  end

  usbh_ints_sync #(.STAGES(STAGES)) u_req_sync (
    .clk(clk_core), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  // core side: one pulse per observed toggle; the seen copy is the ack
  always_ff @(posedge clk_core or negedge rst_n) begin
    if (!rst_n) req_seen <= 1'b0;
    else        req_seen <= req_s;
  end

  assign clr_pulse = req_s ^ req_seen;
  assign clr_mask  = mask_q;

  usbh_ints_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk(clk_bus), .rst_n(rst_n), .d(req_seen), .q(ack_s)
  );

  assign busy = req_tgl ^ ack_s;
endmodule

// File: rtl/usbh_ints_core.sv
module usbh_ints_core
  import usbh_ints_pkg::*;
#(
  parameter int N_EVT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] rh_evt,
  input  logic             frm_msb,
  input  logic             clr_pulse,
  input  src_vec_t         clr_mask,
  output src_vec_t         stat
);
  logic     frm_prev;
  src_vec_t set_v;
  src_vec_t clr_v;

  always_comb begin
    set_v         = '0;
    set_v[SRC_RH] = |rh_evt;
    set_v[SRC_FN] = frm_msb ^ frm_prev;
    clr_v         = clr_pulse ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_prev <= 1'b0;
      stat     <= '0;
    end else begin
      frm_prev <= frm_msb;
      stat     <= (stat & ~clr_v) | set_v;
    end
  end
endmodule

// File: rtl/usbh_int_status.sv
module usbh_int_status
  import usbh_ints_pkg::*;
#(
  parameter int N_PORTS     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_bus,
  input  logic              clk_core,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [N_PORTS:0]  rh_evt_i,
  input  logic              frm_msb_i,
  output logic              irq_o,
  output logic              clr_busy_o
);
  localparam int N_EVT = N_PORTS + 1;

  src_vec_t stat_core;
  src_vec_t stat_seen;
  src_vec_t clr_mask;
  src_vec_t en_bits;
  src_vec_t wr_src;
  logic     en_master;
  logic     clr_pulse;
  logic     accept;
  logic     launch;
  logic     busy;

  assign wr_src     = pick_src(wr_data_i);
  assign accept     = wr_valid_i && wr_ready_o;
  assign launch     = accept && (wr_addr_i == A_STAT) && (|wr_src);
  assign wr_ready_o = !busy;
  assign clr_busy_o = busy;

  always_ff @(posedge clk_bus or negedge rst_n) begin
    if (!rst_n) begin
      en_bits   <= '0;
      en_master <= 1'b0;
    end else if (accept && wr_addr_i == A_ENAB) begin
      en_bits   <= wr_src;
      en_master <= wr_data_i[BIT_MIE];
    end
  end

  usbh_ints_clr_xfer #(.STAGES(SYNC_STAGES), .W(N_SRC)) u_xfer (
    .clk_bus   (clk_bus),
    .clk_core  (clk_core),
    .rst_n     (rst_n),
    .launch    (launch),
    .mask_in   (wr_src),
    .busy      (busy),
    .clr_pulse (clr_pulse),
    .clr_mask  (clr_mask)
  );

  usbh_ints_core #(.N_EVT(N_EVT)) u_core (
    .clk       (clk_core),
    .rst_n     (rst_n),
    .rh_evt    (rh_evt_i),
    .frm_msb   (frm_msb_i),
    .clr_pulse (clr_pulse),
    .clr_mask  (clr_mask),
    .stat      (stat_core)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_stat_sync
    usbh_ints_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_bus), .rst_n(rst_n), .d(stat_core[g]), .q(stat_seen[g])
    );
  end

  always_comb begin
    unique case (rd_addr_i)
      A_STAT:  rd_data_o = place_src(stat_seen);
      A_ENAB:  begin
        rd_data_o          = place_src(en_bits);
        rd_data_o[BIT_MIE] = en_master;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign irq_o = en_master && (|(stat_seen & en_bits));
endmodule

// File: rtl/usbh_int_status_chk.sv
module usbh_int_status_chk
  import usbh_ints_pkg::*;
#(
  parameter int N_PORTS = 2
) (
  input logic              clk_bus,
  input logic              clk_core,
  input logic              rst_n,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [N_PORTS:0]  rh_evt_i,
  input logic              frm_msb_i,
  input logic              irq_o,
  input logic              en_master,
  input src_vec_t          stat_seen,
  input src_vec_t          stat_core,
  input logic              clr_pulse,
  input src_vec_t          clr_mask
);
  AST_NO_IRQ_WITHOUT_MASTER: assert property (@(posedge clk_bus) disable iff (!rst_n)
    irq_o |-> en_master); // R8

  AST_STALL_AFTER_CLEAR: assert property (@(posedge clk_bus) disable iff (!rst_n)
    (wr_valid_i && wr_ready_o && wr_addr_i == A_STAT && (|pick_src(wr_data_i))) |=> !wr_ready_o); // R9

  AST_STICKY_SEEN: assert property (@(posedge clk_bus) disable iff (!rst_n)
    (($past(stat_seen) & ~stat_seen) != '0) |-> !$past(wr_ready_o)); // R4

  AST_SET_NEEDS_EVENT: assert property (@(posedge clk_core) disable iff (!rst_n)
    $rose(stat_core[SRC_RH]) |-> $past(|rh_evt_i)); // R6

  AST_CLEAR_NEEDS_REQ: assert property (@(posedge clk_core) disable iff (!rst_n)
    (($past(stat_core) & ~stat_core) != '0) |-> $past(clr_pulse)); // R5

  AST_SET_WINS: assert property (@(posedge clk_core) disable iff (!rst_n)
    ((|rh_evt_i) && clr_pulse && clr_mask[SRC_RH]) |=> stat_core[SRC_RH]); // R10

  AST_FRAME_TOGGLE: assert property (@(posedge clk_core) disable iff (!rst_n)
    (frm_msb_i != $past(frm_msb_i)) |=> stat_core[SRC_FN]); // R3
endmodule

bind usbh_int_status usbh_int_status_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk_bus    (clk_bus),
  .clk_core   (clk_core),
  .rst_n      (rst_n),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .rh_evt_i   (rh_evt_i),
  .frm_msb_i  (frm_msb_i),
  .irq_o      (irq_o),
  .en_master  (en_master),
  .stat_seen  (stat_seen),
  .stat_core  (stat_core),
  .clr_pulse  (clr_pulse),
  .clr_mask   (clr_mask)
);

// File: tb/sim_usbh_int_status.sv
module sim_usbh_int_status;
  localparam int BUS_PERIOD  = 20;
  localparam int CORE_PERIOD = 7;
  localparam int N_PORTS     = 2;

  logic        clk_bus = 1'b0;
  logic        clk_core = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [N_PORTS:0] rh_evt = '0;
  logic        frm_msb = 1'b0;
  logic        irq;
  logic        busy;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] exp_stat = '0;
  logic [31:0] exp_en = '0;

  always #(BUS_PERIOD/2)  clk_bus  = ~clk_bus;
  always #(CORE_PERIOD/2) clk_core = ~clk_core;

  usbh_int_status #(.N_PORTS(N_PORTS)) u0 (
    .clk_bus(clk_bus), .clk_core(clk_core), .rst_n(rst_n),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rh_evt_i(rh_evt), .frm_msb_i(frm_msb), .irq_o(irq), .clr_busy_o(busy)
  );

  function automatic logic exp_irq();
    return exp_en[31] && (|(exp_stat & exp_en & 32'h0000_0060));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_bus);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    while (!wr_ready) @(negedge clk_bus);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_bus);
    wr_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk_bus);
  endtask

  task automatic pulse_rh(input int idx);
    @(negedge clk_core);
    rh_evt[idx] = 1'b1;
    @(negedge clk_core);
    rh_evt = '0;
    exp_stat[6] = 1'b1;
  endtask

  task automatic flip_frame();
    @(negedge clk_core);
    frm_msb = ~frm_msb;
    exp_stat[5] = 1'b1;
  endtask

  task automatic compare_all(input string req);
    logic [31:0] d;
    settle();
    rd(2'd0, d);
    check(req, d, exp_stat);
    check({req, " irq R8"}, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_bus);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_bus);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_bus);

    // R1 reset state
    rd(2'd0, d); check("R1 stat", d, 32'h0);
    rd(2'd1, d); check("R1 enab", d, 32'h0);
    check("R1 irq/ready/busy", {29'd0, irq, wr_ready, busy}, 32'h2);

    // R11 enable read-back, only bits 31/6/5 kept
    wr(2'd1, 32'hFFFF_FFFF); exp_en = 32'h8000_0060;
    rd(2'd1, d); check("R11 enab readback", d, exp_en);

    // R2 each hub/port strobe sets bit 6; R4 sticky
    for (int i = 0; i <= N_PORTS; i++) begin
      pulse_rh(i);
      compare_all("R2 rh event");
      settle();
      rd(2'd0, d); check("R4 sticky", d, exp_stat);
      wr(2'd0, 32'h40); exp_stat[6] = 1'b0;
      compare_all("R5 clear rh");
    end

    // R3 both directions
    flip_frame(); compare_all("R3 rise");
    wr(2'd0, 32'h20); exp_stat[5] = 1'b0; compare_all("R5 clear fn");
    flip_frame(); compare_all("R3 fall");

    // R5 writing 0 is no effect; R6 writes never set; R7 reserved bits
    pulse_rh(1);
    wr(2'd0, 32'h0); compare_all("R5 zero write");
    wr(2'd0, 32'hFFFF_FF9F); compare_all("R6 R7 write ones elsewhere");
    wr(2'd0, 32'hFFFF_FFFF); exp_stat = '0; compare_all("R5 clear both");
    wr(2'd0, 32'hFFFF_FFFF); compare_all("R6 no set by write");

    // R9 latency of a clear
    pulse_rh(0); settle();
    @(negedge clk_bus);
    while (!wr_ready) @(negedge clk_bus);
    wr_valid = 1'b1; wr_addr = 2'd0; wr_data = 32'h40;
    @(negedge clk_bus);
    wr_valid = 1'b0;
    check("R9 stall", {30'd0, wr_ready, busy}, 32'h1);
    rd_addr = 2'd0; #1 check("R9 not yet cleared", rd_data & 32'h40, 32'h40);
    begin
      int n = 0;
      while (!wr_ready && n < 10) begin @(negedge clk_bus); n++; end
      check("R9 ready returns", {31'd0, n <= 6}, 32'd1);
    end
    #1 check("R9 cleared at ready", rd_data & 32'h40, 32'h0);
    exp_stat[6] = 1'b0;

    // R10 event held across a clear: set wins
    @(negedge clk_core); rh_evt[2] = 1'b1; exp_stat[6] = 1'b1;
    settle();
    wr(2'd0, 32'h40);
    compare_all("R10 set wins");
    @(negedge clk_core); rh_evt = '0;
    wr(2'd0, 32'h40); exp_stat[6] = 1'b0; compare_all("R10 then clear");

    // R8 master gates irq
    pulse_rh(0);
    wr(2'd1, 32'h0000_0060); exp_en = 32'h60; compare_all("R8 master off");
    wr(2'd1, 32'h8000_0020); exp_en = 32'h8000_0020; compare_all("R8 other enable");
    wr(2'd1, 32'h8000_0040); exp_en = 32'h8000_0040; compare_all("R8 on");

    // random mix
    for (int k = 0; k < 60; k++) begin
      int op = $urandom % 5;
      logic [31:0] r = $urandom;
      case (op)
        0: pulse_rh($urandom % (N_PORTS + 1));
        1: flip_frame();
        2: begin wr(2'd0, r); exp_stat &= ~r; end
        3: begin wr(2'd1, r); exp_en = r & 32'h8000_0060; end
        default: begin rd(2'd1, d); check("R11 random enab", d, exp_en); end
      endcase
      compare_all("R2 R3 R5 R8 random");
    end

    done = 1'b1;
    finish_run();
  end
endmodule